// File: doc/BRIEF.md
# Motor Bridge Serial Control and Diagnosis Port

This block is the serial slave port of a motor bridge controller. A host selects it by pulling chip select low, clocks eight bits in on the data input, and reads eight bits of diagnosis back on the data output during the same transfer. When chip select returns high, the received byte becomes the committed control word. From that word come the over-voltage lockout enable, the chopper off-time code, the decay mode and the current-limit code. A one-cycle clear request goes to the diagnosis logic when the word asks for a status reset.

All three serial pins are sampled by the fast system clock through two-flop synchronizers, and their edges are found in that clock domain. A small state machine has three states. `ST_IDLE` means deselected. `ST_FLAG` means selected with no serial clock edge yet; in this state the error flag (diagnosis bit 0) is driven on the data output, so the host can read it without clocking. `ST_XFER` means shifting. The transitions are:
- select: `ST_IDLE` to `ST_FLAG` on a chip-select fall.
- first clock: `ST_FLAG` to `ST_XFER` on a serial-clock rise.
- abort: `ST_FLAG` to `ST_IDLE` on a chip-select rise.
- end: `ST_XFER` to `ST_IDLE` on a chip-select rise.

Data moves through the block as follows. The transmit shifter reloads from the diagnosis word at the first serial-clock rise. It then refills from the received bits, so the port can sit in a daisy chain. A transfer commits only if its bit count is a nonzero multiple of eight.

The data output is a pair: a data bit and an output enable. The pad buffer turns this pair into a tristate pin.

Top module: `motor_ctl_spi_slave`

## Requirements
- R1: The data input is sampled at each falling serial-clock edge inside a transfer, least significant bit first: the first sampled bit ends up as control bit 0.
- R2: `spi_miso_oe` is high while chip select is low and low while it is high. The diagnosis word is shifted out least significant bit first, and the output changes only on rising serial-clock edges.
- R3: At chip-select rise, the last eight received bits become the control word. The committed fields are: bit 6 drives `ovlo_en`, bits 4:3 drive `toff_code`, bit 2 drives `fast_decay` (1 = fast), and bits 1:0 drive `ilim_code`. Bit 5 is ignored. The fields do not change at any other time.
- R4: A committed bit 7 produces a `status_clr` pulse exactly one clock long, in the cycle after the detected chip-select rise. It is not held.
- R5: While selected with the serial clock idle low, `spi_miso` follows `diag_word[0]`. Deselecting without any clock edge leaves the control fields unchanged.
- R6: A transfer whose bit count is not a nonzero multiple of eight is discarded, and the previous control word stays.
- R7: In a transfer of 16 bits, the last eight received bits are committed. The output bits 9 to 16 repeat the first eight input bits in order.
- R8: Reset clears every control field and `status_clr` and disables the output.
- R9: The diagnosis word is captured at the first rising serial-clock edge. Later changes of `diag_word` within the same transfer do not alter the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on or leaving standby) |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| diag_word | input | 8 | Diagnosis word from the fault logic; bit 0 is the error flag |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for the data pad |
| status_clr | output | 1 | One-cycle request to clear latched diagnosis |
| ovlo_en | output | 1 | Over-voltage lockout enable |
| toff_code | output | 2 | Chopper off-time code |
| fast_decay | output | 1 | Decay mode, 1 = fast |
| ilim_code | output | 2 | Chopper current-limit code |

## Verification
The bench sweeps all 256 control words, each against a different diagnosis word. For every word it checks the fields, the bits read back and the count of clear pulses. A design that shifted most significant bit first, or misplaced a field, fails this sweep at once. A design that held the clear request as a level reports more than one pulse.

Short transfers of 5 and 10 bits target a commit that ignores the bit count; such a design would overwrite the control word. A 16-bit chained transfer targets a transmit shifter that fills with zeros instead of received bits. The bench also changes the diagnosis word in the middle of a transfer, which exposes a design that captures late. Finally, it holds the port selected with no clock, which exposes a design that leaves the output tristated or shows the wrong bit before the first edge.

// File: rtl/spi_link_pkg.sv
package spi_link_pkg;
    localparam int WORD_W   = 8;
    localparam int POS_CLR  = 7;
    localparam int POS_OVLO = 6;
    localparam int POS_RSVD = 5;
    localparam int POS_TOFF = 3;
    localparam int POS_DEC  = 2;
    localparam int POS_ILIM = 0;
    localparam int CODE_W   = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FLAG = 2'd1,
        ST_XFER = 2'd2
    } link_state_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int               LANES   = 3,
    parameter logic [LANES-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] din,
    output logic [LANES-1:0] lvl
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic meta_q, safe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                safe_q <= RST_VAL[g];
            end else begin
                meta_q <= din[g];
                safe_q <= meta_q;
            end
        end
        assign lvl[g] = safe_q;
    end
endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det #(
    parameter int               LANES   = 2,
    parameter logic [LANES-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lvl,
    output logic [LANES-1:0] rise,
    output logic [LANES-1:0] fall
);
    for (genvar g = 0; g < LANES; g++) begin : g_edge
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= RST_VAL[g];
            else        prev_q <= lvl[g];
        end
        assign rise[g] = lvl[g] & ~prev_q;
        assign fall[g] = ~lvl[g] & prev_q;
    end
endmodule

// File: rtl/spi_link_fsm.sv
module spi_link_fsm
    import spi_link_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_fall,
    input  logic cs_rise,
    input  logic sck_rise,
    input  logic sck_fall,
    input  logic word_ok,
    output logic start_o,
    output logic load_o,
    output logic shift_o,
    output logic sample_o,
    output logic commit_o,
    output logic oe_o,
    output logic flag_sel_o
);
    link_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (cs_fall) st_d = ST_FLAG;
            ST_FLAG: begin
                if (cs_rise)       st_d = ST_IDLE;
                else if (sck_rise) st_d = ST_XFER;
            end
            ST_XFER: if (cs_rise) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        start_o    = 1'b0;
        load_o     = 1'b0;
        shift_o    = 1'b0;
        sample_o   = 1'b0;
        commit_o   = 1'b0;
        oe_o       = 1'b0;
        flag_sel_o = 1'b0;
        unique case (st_q)
            ST_IDLE: start_o = cs_fall;
            ST_FLAG: begin
                oe_o       = 1'b1;
                flag_sel_o = 1'b1;
                load_o     = sck_rise & ~cs_rise;
            end
            ST_XFER: begin
                oe_o     = 1'b1;
                shift_o  = sck_rise;
                sample_o = sck_fall;
                commit_o = cs_rise & word_ok;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/spi_shift_pair.sv
module spi_shift_pair #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic         sample_i,
    input  logic         oe_i,
    input  logic         flag_sel_i,
    input  logic         sdi_i,
    input  logic [W-1:0] diag_i,
    output logic [W-1:0] rx_o,
    output logic         word_ok_o,
    output logic         sdo_o
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);

    logic [W-1:0]     rx_q, tx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q   <= '0;
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else if (start_i) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else if (sample_i) begin
            rx_q <= {sdi_i, rx_q[W-1:1]};
            if (cnt_q == CNT_LAST) begin
                cnt_q  <= '0;
                full_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tx_q <= '0;
        else if (load_i)  tx_q <= diag_i;
        else if (shift_i) tx_q <= {rx_q[W-1], tx_q[W-1:1]};
    end

    assign rx_o      = rx_q;
    assign word_ok_o = full_q && (cnt_q == '0);
    assign sdo_o     = flag_sel_i ? diag_i[0] : (oe_i & tx_q[0]);
endmodule

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs
    import spi_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              clr_o,
    output logic              ovlo_o,
    output logic [CODE_W-1:0] toff_o,
    output logic              fast_o,
    output logic [CODE_W-1:0] ilim_o
);
    logic unused_rsvd;
    assign unused_rsvd = word_i[POS_RSVD];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_o  <= 1'b0;
            ovlo_o <= 1'b0;
            toff_o <= '0;
            fast_o <= 1'b0;
            ilim_o <= '0;
        end else begin
            clr_o <= commit_i & word_i[POS_CLR];
            if (commit_i) begin
                ovlo_o <= word_i[POS_OVLO];
                toff_o <= word_i[POS_TOFF +: CODE_W];
                fast_o <= word_i[POS_DEC];
                ilim_o <= word_i[POS_ILIM +: CODE_W];
            end
        end
    end
endmodule

// File: rtl/motor_ctl_spi_slave.sv
module motor_ctl_spi_slave
    import spi_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    input  logic [WORD_W-1:0] diag_word,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              status_clr,
    output logic              ovlo_en,
    output logic [CODE_W-1:0] toff_code,
    output logic              fast_decay,
    output logic [CODE_W-1:0] ilim_code
);
    logic [2:0]        pin_lvl;
    logic [1:0]        e_rise, e_fall;
    logic              cs_lvl, cs_rise, cs_fall, sck_rise, sck_fall, sdi_lvl;
    logic              start, load, shift, sample, commit, oe, flag_sel, word_ok;
    logic [WORD_W-1:0] rx_word;

    spi_in_sync #(.LANES(3), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({spi_cs_n, spi_sck, spi_mosi}),
        .lvl(pin_lvl)
    );

    assign cs_lvl  = pin_lvl[2];
    assign sdi_lvl = pin_lvl[0];

    spi_edge_det #(.LANES(2), .RST_VAL(2'b10)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .lvl(pin_lvl[2:1]),
        .rise(e_rise), .fall(e_fall)
    );

    assign cs_rise  = e_rise[1];
    assign cs_fall  = e_fall[1];
    assign sck_rise = e_rise[0];
    assign sck_fall = e_fall[0];

    spi_link_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .word_ok(word_ok),
        .start_o(start), .load_o(load), .shift_o(shift),
        .sample_o(sample), .commit_o(commit),
        .oe_o(oe), .flag_sel_o(flag_sel)
    );

    spi_shift_pair #(.W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .start_i(start), .load_i(load), .shift_i(shift), .sample_i(sample),
        .oe_i(oe), .flag_sel_i(flag_sel),
        .sdi_i(sdi_lvl), .diag_i(diag_word),
        .rx_o(rx_word), .word_ok_o(word_ok), .sdo_o(spi_miso)
    );

    spi_ctl_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .commit_i(commit), .word_i(rx_word),
        .clr_o(status_clr), .ovlo_o(ovlo_en), .toff_o(toff_code),
        .fast_o(fast_decay), .ilim_o(ilim_code)
    );

    assign spi_miso_oe = oe;
endmodule

// File: rtl/spi_link_checker.sv
module spi_link_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_lvl,
    input logic       cs_rise,
    input logic       cs_fall,
    input logic       spi_miso,
    input logic       spi_miso_oe,
    input logic       diag_bit0,
    input logic       status_clr,
    input logic [5:0] fields
);
    // R3: fields move only in the cycle after a detected deselect
    a_r3_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(fields));

    // R4: clear request lasts one cycle
    a_r4_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr |=> !status_clr);

    // R4: clear request only follows a deselect
    a_r4_clr_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr |-> $past(cs_rise));

    // R2: output enabled while selected
    a_r2_oe_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_lvl && $past(!cs_lvl)) |-> spi_miso_oe);

    // R2: output released while deselected
    a_r2_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_lvl && $past(cs_lvl)) |-> !spi_miso_oe);

    // R5: error flag on the output right after select
    a_r5_flag_on_select: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_fall) |-> (spi_miso == diag_bit0));
endmodule

bind motor_ctl_spi_slave spi_link_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .cs_lvl(cs_lvl), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .diag_bit0(diag_word[0]), .status_clr(status_clr),
    .fields({ovlo_en, toff_code, fast_decay, ilim_code})
);

// File: tb/motor_ctl_spi_slave_tb.sv
module motor_ctl_spi_slave_tb;
    localparam int CLK_P = 10;
    localparam int HP    = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic [7:0] diag_word = 8'h00;
    logic       spi_miso, spi_miso_oe, status_clr, ovlo_en, fast_decay;
    logic [1:0] toff_code, ilim_code;

    int n_chk = 0, n_fail = 0, clr_cnt = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    motor_ctl_spi_slave u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .diag_word(diag_word), .spi_miso(spi_miso),
        .spi_miso_oe(spi_miso_oe), .status_clr(status_clr), .ovlo_en(ovlo_en),
        .toff_code(toff_code), .fast_decay(fast_decay), .ilim_code(ilim_code)
    );

    always @(negedge clk) if (status_clr) clr_cnt++;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] fields_of(input logic [7:0] w);
        return {w[6], w[4:3], w[2], w[1:0]};
    endfunction

    function automatic logic [6:0] fields_now();
        return {ovlo_en, toff_code, fast_decay, ilim_code};
    endfunction

    // drives nbits LSB first; dout[i] is the output seen after rising edge i
    task automatic xfer(input int nbits, input logic [15:0] din, input logic [7:0] late_diag,
                        output logic [15:0] dout);
        dout = '0;
        spi_cs_n = 1'b0;
        step(HP);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = din[i];
            spi_sck  = 1'b1;
            step(HP);
            dout[i] = spi_miso;
            if (i == 0) diag_word = late_diag;
            spi_sck = 1'b0;
            step(HP);
        end
        spi_cs_n = 1'b1;
        step(HP);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] got;
        logic [6:0]  keep;
        int          c0;
        step(3);
        // R8: reset state
        chk(fields_now() == 7'h0 && !status_clr && !spi_miso_oe, "R8 reset",
            {fields_now(), status_clr, spi_miso_oe}, 0);
        rst_n = 1'b1;
        step(4);

        // R1 R2 R3 R4: all control words
        for (int w = 0; w < 256; w++) begin
            logic [7:0] d;
            d = 8'(w * 37 + 11);
            diag_word = d;
            c0 = clr_cnt;
            xfer(8, 16'(w), d, got);
            chk(fields_now() == fields_of(8'(w)), "R1/R3 fields", fields_now(), fields_of(8'(w)));
            chk(got[7:0] == d, "R2 diag readback", got[7:0], d);
            chk(clr_cnt - c0 == int'(w[7]), "R4 clear pulse count", clr_cnt - c0, w[7]);
            chk(!spi_miso_oe, "R2 released", spi_miso_oe, 0);
        end

        // R5: error-only read, no clock
        keep = fields_now();
        for (int b = 0; b < 2; b++) begin
            diag_word = {7'h55, b[0]};
            spi_cs_n = 1'b0;
            step(HP);
            chk(spi_miso_oe && spi_miso == b[0], "R5 flag shown", {spi_miso_oe, spi_miso}, {1'b1, b[0]});
            diag_word[0] = ~b[0];
            step(2);
            chk(spi_miso == ~b[0], "R5 flag follows", spi_miso, ~b[0]);
            spi_cs_n = 1'b1;
            step(HP);
            chk(fields_now() == keep, "R5 no commit", fields_now(), keep);
        end

        // R6: partial transfers discarded
        xfer(8, 16'h001B, 8'h00, got);
        keep = fields_of(8'h1B);
        xfer(5, 16'h0004, 8'h00, got);
        chk(fields_now() == keep, "R6 five bits", fields_now(), keep);
        xfer(10, 16'h03E4, 8'h00, got);
        chk(fields_now() == keep, "R6 ten bits", fields_now(), keep);

        // R7: chained 16-bit transfer
        diag_word = 8'hC3;
        xfer(16, 16'h4DA6, 8'hC3, got);
        chk(fields_now() == fields_of(8'h4D), "R7 last byte commits", fields_now(), fields_of(8'h4D));
        chk(got[15:8] == 8'hA6, "R7 forwarded bits", got[15:8], 8'hA6);
        chk(got[7:0] == 8'hC3, "R7 diag first", got[7:0], 8'hC3);

        // R9: diagnosis captured at first rising edge
        diag_word = 8'h96;
        xfer(8, 16'h0012, 8'h69, got);
        chk(got[7:0] == 8'h96, "R9 capture at first edge", got[7:0], 8'h96);

        // R8: reset mid-operation clears fields
        xfer(8, 16'h005F, 8'h00, got);
        rst_n = 1'b0;
        step(2);
        chk(fields_now() == 7'h0 && !spi_miso_oe, "R8 reset clears", fields_now(), 0);
        rst_n = 1'b1;
        step(4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule